// File: doc/BRIEF.md
# I2C Slave Address Recognizer (7-bit, 10-bit and General Call)

This block sits beside the bit-level receiver of an I2C slave and judges each address byte that arrives after a START or a repeated START. It decides whether the device is being selected. In 7-bit mode one byte settles the question. In 10-bit mode a header byte carrying the two upper address bits must come first, and a second byte carrying the lower eight bits follows it. When general call is enabled, the all-zero write address also selects the device. The outputs are the ACK level for the ninth bit, a single-cycle match interrupt, the captured read/write direction, a status flag for a full 10-bit match, a status flag for general call, and an indicator of whether the last byte was an address byte or a data byte.

A completed byte arrives as a one-cycle valid strobe with its eight bits. The strobe carries no ready signal. The bus cannot be paused by this block, so there is no back-pressure: every strobe is consumed in the cycle it is presented. START, STOP and the falling SCL edge that ends the ninth bit also arrive as one-cycle strobes from the bit-level logic. When START and STOP are seen in the same cycle, STOP wins. Data bytes never reach a receive buffer through this block, and they never raise its flags or its interrupt.

After a full 10-bit match, the match is remembered. This lets a repeated START followed by the read header select slave-transmit mode without a second low-byte compare. A STOP clears that memory.

Top module: `i2c_addr_recog`

## Requirements
- R1: In 7-bit mode (mode10=0) a first byte whose bits [7:1] equal own_addr[6:0] is acknowledged: ack_drive is 1 in the cycle after the byte strobe, and rw_flag takes bit 0 of the byte (1 = read). On a mismatch ack_drive stays 0, and every byte after it is ignored until the next START.
- R2: In 10-bit mode a first byte equal to {5'b11110, own_addr[9:8], 1'b0} is acknowledged and raises no interrupt. The next byte is then treated as the low address byte.
- R3: In 10-bit mode a first byte that does not match the header, or a read header (bit 0 = 1) with no full match remembered, is not acknowledged and clears ten_match. The block ignores bytes until the next START.
- R4: A low address byte equal to own_addr[7:0] is acknowledged, sets ten_match, sets rw_flag to 0 and raises the interrupt. A low byte that differs is not acknowledged and clears ten_match.
- R5: While ten_match is 1, a repeated START followed by the read header {5'b11110, own_addr[9:8], 1'b1} is acknowledged at once. It sets rw_flag to 1 and raises the interrupt, with no low byte needed.
- R6: match_irq is a one-cycle pulse. It appears in the cycle after the ninth_fall strobe, and only when ack_drive was 1 at that strobe. ack_drive returns to 0 in that same cycle.
- R7: With gcall_en=1, a first byte of 8'h00 is acknowledged, sets gcall_hit, sets rw_flag to 0 and raises the interrupt. With gcall_en=0 the same byte is judged as an ordinary address. gcall_hit is cleared by any other first-byte decision.
- R8: A STOP clears ten_match and ack_drive in the next cycle. A read header that follows a STOP and a new START is then not acknowledged.
- R9: last_is_data is 0 after an address byte and 1 after a byte received while the device is selected. Such data bytes leave ack_drive and match_irq at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | One-cycle strobe: START or repeated START seen |
| stop_det | input | 1 | One-cycle strobe: STOP seen |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a complete byte |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| ninth_fall | input | 1 | One-cycle strobe: SCL falling edge ending the ninth bit |
| own_addr | input | 10 | Own slave address (7-bit mode uses [6:0]) |
| mode10 | input | 1 | 1 selects 10-bit addressing |
| gcall_en | input | 1 | 1 enables general-call recognition |
| ack_drive | output | 1 | 1 = pull SDA low (ACK) in the ninth bit |
| match_irq | output | 1 | One-cycle address-match interrupt |
| rw_flag | output | 1 | Captured direction, 1 = slave transmits |
| ten_match | output | 1 | Full 10-bit address match status |
| gcall_hit | output | 1 | General-call address received status |
| last_is_data | output | 1 | 1 = last byte was data, 0 = address |

## Verification
7-bit traffic uses a matching write address, a matching read address, a wrong address, and a correct address sent after a wrong one without a new START. Together these separate the compare from the byte-ignoring that follows a rejection. 10-bit traffic walks through header then low byte, then a repeated START with the read header. It then sends the same read header after a STOP, a low byte that differs in one bit, and a header with the wrong upper bits. These show that the remembered full match, and only it, admits the short read path. The general-call byte is sent with recognition enabled and disabled, and data bytes are sent after selection to show they raise neither ACK nor interrupt.

// File: rtl/i2c_recog_pkg.sv
package i2c_recog_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 10;
  localparam int SHORT_W    = 7;
  localparam int UPPER_W    = ADDR_W - BYTE_W;
  localparam int PREFIX_W   = SHORT_W - UPPER_W;
  localparam logic [PREFIX_W-1:0] HDR_PREFIX = 5'b11110;
  localparam logic [BYTE_W-1:0]   GCALL_BYTE = '0;

  // Sequencer phases
  typedef enum logic [2:0] {
    PH_IDLE,   // no START seen since reset/STOP
    PH_FIRST,  // next byte is the first address byte
    PH_LOW,    // next byte is the 10-bit low address byte
    PH_RX,     // selected, master writes
    PH_TX,     // selected, master reads
    PH_SKIP    // not addressed, wait for START/STOP
  } phase_t;

  // Outcome of judging one address byte
  typedef struct packed {
    logic accept;   // drive ACK
    logic to_low;   // header matched, low byte pending
    logic rw;       // direction to capture
    logic set_ten;  // full 10-bit match reached
    logic clr_ten;  // drop the remembered 10-bit match
    logic gcall;    // general call recognised
    logic irq;      // raise interrupt after ninth bit
  } verdict_t;
endpackage

// File: rtl/i2c_recog_compare.sv
// Pure combinational judgement of one address byte.
module i2c_recog_compare
  import i2c_recog_pkg::*;
(
  input  logic              low_phase,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              mode10,
  input  logic              gcall_en,
  input  logic              ten_held,
  output verdict_t          verdict
);
  logic [SHORT_W-1:0] hdr_pattern;
  logic               hit_short;
  logic               hit_hdr;
  logic               hit_low;
  logic               is_gcall;
  logic               rd_bit;

  assign hdr_pattern = {HDR_PREFIX, own_addr[ADDR_W-1 -: UPPER_W]};
  assign rd_bit      = byte_in[0];
  assign hit_short   = (byte_in[BYTE_W-1:1] == own_addr[SHORT_W-1:0]);
  assign hit_hdr     = (byte_in[BYTE_W-1:1] == hdr_pattern);
  assign hit_low     = (byte_in == own_addr[BYTE_W-1:0]);
  assign is_gcall    = gcall_en && (byte_in == GCALL_BYTE);

  always_comb begin
    verdict = '0;
    if (low_phase) begin
      // second byte of a 10-bit address
      if (hit_low) begin
        verdict.accept  = 1'b1;
        verdict.set_ten = 1'b1;
        verdict.irq     = 1'b1;
      end else begin
        verdict.clr_ten = 1'b1;
      end
    end else if (is_gcall) begin
      verdict.accept = 1'b1;
      verdict.gcall  = 1'b1;
      verdict.irq    = 1'b1;
    end else if (!mode10) begin
      if (hit_short) begin
        verdict.accept = 1'b1;
        verdict.rw     = rd_bit;
        verdict.irq    = 1'b1;
      end
    end else if (hit_hdr && !rd_bit) begin
      // header write: partial match, low byte follows
      verdict.accept  = 1'b1;
      verdict.to_low  = 1'b1;
      verdict.clr_ten = 1'b1;
    end else if (hit_hdr && rd_bit && ten_held) begin
      // read header after full match: straight to transmit
      verdict.accept = 1'b1;
      verdict.rw     = 1'b1;
      verdict.irq    = 1'b1;
    end else begin
      verdict.clr_ten = 1'b1;
    end
  end
endmodule

// File: rtl/i2c_recog_seq.sv
// Phase tracking and status flags.
module i2c_recog_seq
  import i2c_recog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_det,
  input  logic     stop_det,
  input  logic     rx_valid,
  input  verdict_t verdict,
  output logic     low_phase,
  output logic     ten_match,
  output logic     gcall_hit,
  output logic     rw_flag,
  output logic     last_is_data,
  output logic     dec_valid,
  output logic     dec_ack,
  output logic     dec_irq
);
  phase_t phase_q;
  logic   addr_byte;
  logic   data_byte;

  assign low_phase = (phase_q == PH_LOW);
  assign addr_byte = rx_valid && !start_det && !stop_det &&
                     (phase_q == PH_FIRST || phase_q == PH_LOW);
  assign data_byte = rx_valid && !start_det && !stop_det &&
                     (phase_q == PH_RX || phase_q == PH_TX);

  // decision strobe to the ninth-bit timer
  assign dec_valid = addr_byte;
  assign dec_ack   = addr_byte && verdict.accept;
  assign dec_irq   = addr_byte && verdict.irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      ten_match    <= 1'b0;
      gcall_hit    <= 1'b0;
      rw_flag      <= 1'b0;
      last_is_data <= 1'b0;
    end else if (stop_det) begin
      phase_q   <= PH_IDLE;
      ten_match <= 1'b0;
    end else if (start_det) begin
      phase_q <= PH_FIRST;
    end else if (addr_byte) begin
      last_is_data <= 1'b0;
      if (!low_phase) gcall_hit <= verdict.gcall;
      if (verdict.set_ten)      ten_match <= 1'b1;
      else if (verdict.clr_ten) ten_match <= 1'b0;
      if (!verdict.accept) begin
        phase_q <= PH_SKIP;
      end else if (verdict.to_low) begin
        phase_q <= PH_LOW;
      end else begin
        rw_flag <= verdict.rw;
        phase_q <= verdict.rw ? PH_TX : PH_RX;
      end
    end else if (data_byte) begin
      last_is_data <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_recog_ack.sv
// Holds the ACK level through the ninth bit and issues the interrupt.
module i2c_recog_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic dec_valid,
  input  logic dec_ack,
  input  logic dec_irq,
  input  logic ninth_fall,
  output logic ack_drive,
  output logic match_irq
);
  logic irq_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_drive <= 1'b0;
      irq_pend  <= 1'b0;
      match_irq <= 1'b0;
    end else begin
      match_irq <= 1'b0;
      if (start_det || stop_det) begin
        ack_drive <= 1'b0;
        irq_pend  <= 1'b0;
      end else if (dec_valid) begin
        ack_drive <= dec_ack;
        irq_pend  <= dec_irq;
      end else if (ninth_fall) begin
        match_irq <= ack_drive && irq_pend;
        ack_drive <= 1'b0;
        irq_pend  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_recog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ninth_fall,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              mode10,
  input  logic              gcall_en,
  output logic              ack_drive,
  output logic              match_irq,
  output logic              rw_flag,
  output logic              ten_match,
  output logic              gcall_hit,
  output logic              last_is_data
);
  verdict_t verdict;
  logic     low_phase;
  logic     dec_valid;
  logic     dec_ack;
  logic     dec_irq;

  i2c_recog_compare u_cmp (
    .low_phase (low_phase),
    .byte_in   (rx_byte),
    .own_addr  (own_addr),
    .mode10    (mode10),
    .gcall_en  (gcall_en),
    .ten_held  (ten_match),
    .verdict   (verdict)
  );

  i2c_recog_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .rx_valid     (rx_valid),
    .verdict      (verdict),
    .low_phase    (low_phase),
    .ten_match    (ten_match),
    .gcall_hit    (gcall_hit),
    .rw_flag      (rw_flag),
    .last_is_data (last_is_data),
    .dec_valid    (dec_valid),
    .dec_ack      (dec_ack),
    .dec_irq      (dec_irq)
  );

  i2c_recog_ack u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .dec_valid  (dec_valid),
    .dec_ack    (dec_ack),
    .dec_irq    (dec_irq),
    .ninth_fall (ninth_fall),
    .ack_drive  (ack_drive),
    .match_irq  (match_irq)
  );
endmodule

// File: rtl/i2c_addr_recog_chk.sv
module i2c_addr_recog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_det,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       ninth_fall,
  input logic       mode10,
  input logic       gcall_en,
  input logic       ack_drive,
  input logic       match_irq,
  input logic       ten_match,
  input logic       gcall_hit
);
  // R6: interrupt only after a ninth bit that carried ACK
  assert_irq_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> ($past(ninth_fall) && $past(ack_drive)));

  // R6: interrupt is a single-cycle pulse
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);

  // R8: STOP drops the 10-bit memory and the ACK level
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!ten_match && !ack_drive));

  // R4: full 10-bit match only rises on a byte in 10-bit mode
  assert_ten_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ten_match) |-> ($past(rx_valid) && $past(mode10)));

  // R7: general-call flag only rises on an enabled all-zero byte
  assert_gcall_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcall_hit) |-> ($past(rx_valid) && $past(gcall_en) && ($past(rx_byte) == 8'h00)));
endmodule

bind i2c_addr_recog i2c_addr_recog_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_det   (stop_det),
  .rx_valid   (rx_valid),
  .rx_byte    (rx_byte),
  .ninth_fall (ninth_fall),
  .mode10     (mode10),
  .gcall_en   (gcall_en),
  .ack_drive  (ack_drive),
  .match_irq  (match_irq),
  .ten_match  (ten_match),
  .gcall_hit  (gcall_hit)
);

// File: tb/i2c_addr_recog_tb.sv
`timescale 1ns/1ps
module i2c_addr_recog_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_det = 1'b0;
  logic       stop_det = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ninth_fall = 1'b0;
  logic [9:0] own_addr = 10'h000;
  logic       mode10 = 1'b0;
  logic       gcall_en = 1'b0;
  logic       ack_drive, match_irq, rw_flag, ten_match, gcall_hit, last_is_data;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  i2c_addr_recog u_dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .ninth_fall(ninth_fall),
    .own_addr(own_addr), .mode10(mode10), .gcall_en(gcall_en),
    .ack_drive(ack_drive), .match_irq(match_irq), .rw_flag(rw_flag),
    .ten_match(ten_match), .gcall_hit(gcall_hit), .last_is_data(last_is_data)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
  endtask

  // One byte plus its ninth bit; returns ACK level and interrupt seen
  task automatic put_byte(input logic [7:0] b, output logic ack, output logic irq);
    @(negedge clk) begin rx_byte = b; rx_valid = 1'b1; end
    @(negedge clk) begin rx_valid = 1'b0; ack = ack_drive; ninth_fall = 1'b1; end
    @(negedge clk) begin ninth_fall = 1'b0; irq = match_irq; end
  endtask

  task automatic t_reset();
    chk("R6 reset ack_drive", ack_drive, 1'b0);
    chk("R6 reset match_irq", match_irq, 1'b0);
    chk("R4 reset ten_match", ten_match, 1'b0);
    chk("R7 reset gcall_hit", gcall_hit, 1'b0);
  endtask

  task automatic t_seven();
    logic a, i;
    mode10 = 1'b0; gcall_en = 1'b0; own_addr = 10'h32A; // [6:0] = 0x2A
    pulse_start();
    put_byte(8'h54, a, i);
    chk("R1 write addr ack", a, 1'b1);
    chk("R6 write addr irq", i, 1'b1);
    chk("R6 ack released after ninth", ack_drive, 1'b0);
    chk("R1 rw write", rw_flag, 1'b0);
    chk("R9 addr marks address", last_is_data, 1'b0);
    put_byte(8'h33, a, i);
    chk("R9 data no ack", a, 1'b0);
    chk("R9 data no irq", i, 1'b0);
    chk("R9 data marks data", last_is_data, 1'b1);
    pulse_stop();
    pulse_start();
    put_byte(8'h55, a, i);
    chk("R1 read addr ack", a, 1'b1);
    chk("R1 rw read", rw_flag, 1'b1);
    pulse_stop();
    pulse_start();
    put_byte(8'h56, a, i);
    chk("R1 mismatch nack", a, 1'b0);
    chk("R6 mismatch no irq", i, 1'b0);
    put_byte(8'h54, a, i);
    chk("R1 ignored after mismatch", a, 1'b0);
    pulse_stop();
  endtask

  task automatic t_ten();
    logic a, i;
    mode10 = 1'b1; gcall_en = 1'b0; own_addr = 10'h2C5; // header 0xF4/0xF5, low 0xC5
    pulse_start();
    put_byte(8'hF5, a, i);
    chk("R3 read header before match nack", a, 1'b0);
    chk("R3 ten clear", ten_match, 1'b0);
    pulse_start();
    put_byte(8'hF4, a, i);
    chk("R2 header ack", a, 1'b1);
    chk("R2 header no irq", i, 1'b0);
    chk("R2 no full match yet", ten_match, 1'b0);
    put_byte(8'hC5, a, i);
    chk("R4 low ack", a, 1'b1);
    chk("R4 low irq", i, 1'b1);
    chk("R4 ten set", ten_match, 1'b1);
    chk("R4 rw write", rw_flag, 1'b0);
    pulse_start();
    put_byte(8'hF5, a, i);
    chk("R5 restart read ack", a, 1'b1);
    chk("R5 restart read irq", i, 1'b1);
    chk("R5 rw read", rw_flag, 1'b1);
    chk("R5 ten kept", ten_match, 1'b1);
    pulse_stop();
    chk("R8 stop clears ten", ten_match, 1'b0);
    pulse_start();
    put_byte(8'hF5, a, i);
    chk("R8 read header after stop nack", a, 1'b0);
    pulse_start();
    put_byte(8'hF4, a, i);
    put_byte(8'hC4, a, i);
    chk("R4 low mismatch nack", a, 1'b0);
    chk("R4 low mismatch ten clear", ten_match, 1'b0);
    pulse_start();
    put_byte(8'hF6, a, i);
    chk("R3 wrong upper bits nack", a, 1'b0);
    put_byte(8'hC5, a, i);
    chk("R3 ignored after header miss", a, 1'b0);
    pulse_stop();
  endtask

  task automatic t_gcall();
    logic a, i;
    mode10 = 1'b0; own_addr = 10'h02A; gcall_en = 1'b1;
    pulse_start();
    put_byte(8'h00, a, i);
    chk("R7 gcall ack", a, 1'b1);
    chk("R7 gcall irq", i, 1'b1);
    chk("R7 gcall flag", gcall_hit, 1'b1);
    chk("R7 gcall rw", rw_flag, 1'b0);
    pulse_stop();
    gcall_en = 1'b0;
    pulse_start();
    put_byte(8'h00, a, i);
    chk("R7 gcall disabled nack", a, 1'b0);
    chk("R7 gcall flag cleared", gcall_hit, 1'b0);
    pulse_stop();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seven();
    t_ten();
    t_gcall();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule